// File: doc/BRIEF.md
# Multiplexed System Bus Request Master

This block is the processor-side master of a 64-bit system bus on which addresses and data share the same wires. An internal requester, such as a cache-miss engine or a write buffer, presents a read or a write. The master then drives one address cycle, followed for writes by one or more data cycles. Every cycle it drives carries a 9-bit command word, which marks the cycle as address or data, and one even-parity check bit for each byte lane.

Reads and writes are each gated by an active-low ready input from the external device. Read data comes back as data cycles that the device paces freely, with any number of idle cycles between words. The master takes each word as it arrives, checks the parity of each lane, and passes the word to the requester along with last-word and error indications. Only one read may be in flight at a time.

Transfers are either a single word moving 1 to 8 bytes, whose low three address bits give the starting byte, or a 32-byte block made of four data words.

Top module: `sysbus_master`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `ad_out_en`, `wd_pop`, `rsp_valid` and `err_sticky` are 0. With both ready inputs low, `req_ready` is 1 in that first cycle.
- R2: When a request is accepted (`req_valid` and `req_ready` high at a clock edge), the next cycle is an address cycle. In that cycle `ad_out_en`=1 and `ad_out` is `req_addr` zero-extended. `cmd_out` is built as follows: bit8=0; bits7:5 = 000 for a read and 001 for a write; bit4 = the block flag; bit3=0; bits2:0 = byte count minus one for a single transfer and 000 for a block.
- R3: A write's address cycle is followed at once by consecutive data cycles, one for a single write and four for a block write. Each data cycle carries the `wd_data` value present in the cycle before it, during which `wd_pop` is 1. The data command is bit8=1, bit7=last, bit6=0 and bits5:0=0, and the last flag is set only on the final data cycle.
- R4: In every cycle with `ad_out_en`=1, `adc_out[i]` is the XOR of byte i of `ad_out`, so each lane together with its check bit holds an even number of ones.
- R5: While `rd_rdy_n` is 1 no read is accepted, and while `wr_rdy_n` is 1 no write is accepted. In both cases `req_ready` is 0 and no address cycle follows.
- R6: While a read is pending, an input cycle counts as read data when `ad_in_valid`=1, `cmd_in[8]`=1 and `cmd_in[5:0]`=0. One cycle after each such input, `rsp_valid`=1, `rsp_data` equals `ad_in`, and `rsp_last` equals `cmd_in[7]`. Idle gaps of any length between words are allowed.
- R7: `rsp_err` is 1 for a word whose lane parity does not match `adc_in` or whose `cmd_in[6]` is set. A parity mismatch also sets `err_sticky`, which stays at 1 until reset. The `cmd_in[6]` flag alone does not set `err_sticky`.
- R8: From the acceptance of a read until the cycle after its last-flagged data word, `req_ready` is 0. In the cycle after the last word, `req_ready` is 1 again.
- R9: Input cycles are ignored, and produce no `rsp_valid`, if they arrive while no read is pending or if they have nonzero `cmd_in[5:0]`.
- R10: `ad_out_en` is 0 in every cycle that is neither an address cycle nor a write data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_block | input | 1 | 1 = 32-byte block transfer |
| req_nbytes | input | 4 | Byte count 1..8 for a single transfer |
| req_addr | input | ADDR_W | Transfer address |
| wd_data | input | DATA_W | Write data word for the next data cycle |
| wd_pop | output | 1 | Current `wd_data` is consumed at the coming edge |
| rd_rdy_n | input | 1 | Device can take a read (active low) |
| wr_rdy_n | input | 1 | Device can take a write (active low) |
| ad_out | output | DATA_W | Outbound address/data |
| adc_out | output | DATA_W/8 | Outbound lane parity |
| cmd_out | output | 9 | Outbound command word |
| ad_out_en | output | 1 | Master is driving the bus this cycle |
| ad_in | input | DATA_W | Inbound address/data |
| adc_in | input | DATA_W/8 | Inbound lane parity |
| cmd_in | input | 9 | Inbound command word |
| ad_in_valid | input | 1 | Device is driving the bus this cycle |
| rsp_valid | output | 1 | Read word delivered |
| rsp_data | output | DATA_W | Read word |
| rsp_last | output | 1 | Final word of the read |
| rsp_err | output | 1 | Word had a parity or flagged error |
| err_sticky | output | 1 | A parity mismatch has occurred since reset |

## Verification
Writes are driven as a 3-byte single transfer at an unaligned address and as a four-word block. These two patterns separate the byte-count field from the block encoding, and show that the last flag appears only on the final beat. Reads are tried with an immediate single 8-byte response and with a block whose words arrive after uneven idle gaps, which shows that the master follows the device's pace and holds off new requests until the last word. Stray and malformed input cycles, a device-flagged error word and a corrupted lane separate ignored traffic, a per-word error and the sticky parity status. Deasserted ready inputs show that each request type is gated by its own ready signal.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;

  localparam int CMD_W = 9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WDATA,
    ST_RWAIT
  } seq_state_t;

  // Address-cycle command: kind in bit8=0, type in bits7:5, block in bit4,
  // byte count minus one in bits2:0.
  function automatic logic [CMD_W-1:0] addr_cmd(input logic wr, input logic blk,
                                                 input logic [2:0] cnt_m1);
    return {1'b0, 2'b00, wr, blk, 1'b0, cnt_m1};
  endfunction

  // Data-cycle command: bit8=1, bit7 last, bit6 error, rest zero.
  function automatic logic [CMD_W-1:0] data_cmd(input logic last, input logic err);
    return {1'b1, last, err, 6'b000000};
  endfunction

endpackage

// File: rtl/sysbus_parity_gen.sv
module sysbus_parity_gen #(
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  par
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign par[g] = ^data[8*g +: 8];
  end

endmodule

// File: rtl/sysbus_parity_chk.sv
module sysbus_parity_chk #(
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [LANES-1:0]  chk,
  output logic              mismatch
);

  logic [LANES-1:0] calc;

  sysbus_parity_gen #(.DATA_W(DATA_W)) u_gen (
    .data (data),
    .par  (calc)
  );

  assign mismatch = |(calc ^ chk);

endmodule

// File: rtl/sysbus_seq.sv
module sysbus_seq
  import sysbus_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 36,
  parameter int BLOCK_BEATS = 4,
  localparam int LANES      = DATA_W / 8,
  localparam int BEAT_W     = (BLOCK_BEATS > 1) ? $clog2(BLOCK_BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_block,
  input  logic [3:0]        req_nbytes,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] wd_data,
  output logic              wd_pop,
  input  logic              rd_rdy_n,
  input  logic              wr_rdy_n,
  output logic [DATA_W-1:0] ad_nxt,
  input  logic [LANES-1:0]  par_nxt,
  output logic [DATA_W-1:0] ad_out,
  output logic [LANES-1:0]  adc_out,
  output logic [CMD_W-1:0]  cmd_out,
  output logic              ad_out_en,
  input  logic [DATA_W-1:0] ad_in,
  input  logic [CMD_W-1:0]  cmd_in,
  input  logic              ad_in_valid,
  input  logic              in_bad_par,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last,
  output logic              rsp_err,
  output logic              err_sticky
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BLOCK_BEATS - 1);

  seq_state_t        st;
  logic [BEAT_W-1:0] beat;
  logic              blk_q;
  logic              accept;
  logic [3:0]        nb_m1;
  logic [2:0]        cnt_field;
  logic              wr_last;
  logic              in_data;

  assign req_ready = (st == ST_IDLE) && (req_write ? !wr_rdy_n : !rd_rdy_n);
  assign accept    = req_valid && req_ready;
  assign wd_pop    = (st == ST_WDATA);
  assign nb_m1     = req_nbytes - 4'd1;
  assign cnt_field = req_block ? 3'b000 : nb_m1[2:0];
  assign wr_last   = !blk_q || (beat == LAST_BEAT);
  assign in_data   = ad_in_valid && cmd_in[8] && (cmd_in[5:0] == 6'd0);

  always_comb begin
    if (st == ST_IDLE) ad_nxt = DATA_W'(req_addr);
    else               ad_nxt = wd_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      beat       <= '0;
      blk_q      <= 1'b0;
      ad_out     <= '0;
      adc_out    <= '0;
      cmd_out    <= '0;
      ad_out_en  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_last   <= 1'b0;
      rsp_err    <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      ad_out_en <= 1'b0;
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            ad_out_en <= 1'b1;
            ad_out    <= ad_nxt;
            adc_out   <= par_nxt;
            cmd_out   <= addr_cmd(req_write, req_block, cnt_field);
            blk_q     <= req_block;
            beat      <= '0;
            st        <= req_write ? ST_WDATA : ST_RWAIT;
          end
        end
        ST_WDATA: begin
          ad_out_en <= 1'b1;
          ad_out    <= ad_nxt;
          adc_out   <= par_nxt;
          cmd_out   <= data_cmd(wr_last, 1'b0);
          beat      <= beat + 1'b1;
          if (wr_last) st <= ST_IDLE;
        end
        ST_RWAIT: begin
          if (in_data) begin
            rsp_valid <= 1'b1;
            rsp_data  <= ad_in;
            rsp_last  <= cmd_in[7];
            rsp_err   <= in_bad_par | cmd_in[6];
            if (in_bad_par) err_sticky <= 1'b1;
            if (cmd_in[7])  st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sysbus_master.sv
module sysbus_master
  import sysbus_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 36,
  parameter int BLOCK_BEATS = 4,
  localparam int LANES      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_block,
  input  logic [3:0]        req_nbytes,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] wd_data,
  output logic              wd_pop,
  input  logic              rd_rdy_n,
  input  logic              wr_rdy_n,
  output logic [DATA_W-1:0] ad_out,
  output logic [LANES-1:0]  adc_out,
  output logic [CMD_W-1:0]  cmd_out,
  output logic              ad_out_en,
  input  logic [DATA_W-1:0] ad_in,
  input  logic [LANES-1:0]  adc_in,
  input  logic [CMD_W-1:0]  cmd_in,
  input  logic              ad_in_valid,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last,
  output logic              rsp_err,
  output logic              err_sticky
);

  logic [DATA_W-1:0] ad_nxt;
  logic [LANES-1:0]  par_nxt;
  logic              in_bad_par;

  sysbus_parity_gen #(.DATA_W(DATA_W)) u_pgen (
    .data (ad_nxt),
    .par  (par_nxt)
  );

  sysbus_parity_chk #(.DATA_W(DATA_W)) u_pchk (
    .data     (ad_in),
    .chk      (adc_in),
    .mismatch (in_bad_par)
  );

  sysbus_seq #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .BLOCK_BEATS (BLOCK_BEATS)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_block   (req_block),
    .req_nbytes  (req_nbytes),
    .req_addr    (req_addr),
    .wd_data     (wd_data),
    .wd_pop      (wd_pop),
    .rd_rdy_n    (rd_rdy_n),
    .wr_rdy_n    (wr_rdy_n),
    .ad_nxt      (ad_nxt),
    .par_nxt     (par_nxt),
    .ad_out      (ad_out),
    .adc_out     (adc_out),
    .cmd_out     (cmd_out),
    .ad_out_en   (ad_out_en),
    .ad_in       (ad_in),
    .cmd_in      (cmd_in),
    .ad_in_valid (ad_in_valid),
    .in_bad_par  (in_bad_par),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rsp_last    (rsp_last),
    .rsp_err     (rsp_err),
    .err_sticky  (err_sticky)
  );

endmodule

// File: rtl/sysbus_master_chk.sv
module sysbus_master_chk #(
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rd_rdy_n,
  input logic              wr_rdy_n,
  input logic [DATA_W-1:0] ad_out,
  input logic [LANES-1:0]  adc_out,
  input logic [8:0]        cmd_out,
  input logic              ad_out_en,
  input logic [DATA_W-1:0] ad_in,
  input logic              ad_in_valid,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              err_sticky
);

  function automatic logic [LANES-1:0] lane_par(input logic [DATA_W-1:0] d);
    logic [LANES-1:0] p;
    for (int i = 0; i < LANES; i++) p[i] = ^d[8*i +: 8];
    return p;
  endfunction

  // R4
  out_parity_chk: assert property (@(posedge clk) disable iff (rst)
    ad_out_en |-> (adc_out == lane_par(ad_out)));

  // R5
  rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write) |-> !rd_rdy_n);

  // R5
  wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_write) |-> !wr_rdy_n);

  // R2
  addr_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (ad_out_en && !cmd_out[8]));

  // R8
  one_read_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write) |=> !req_ready);

  // R6
  rsp_source_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(ad_in_valid) && (rsp_data == $past(ad_in))));

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky);

endmodule

bind sysbus_master sysbus_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .rd_rdy_n    (rd_rdy_n),
  .wr_rdy_n    (wr_rdy_n),
  .ad_out      (ad_out),
  .adc_out     (adc_out),
  .cmd_out     (cmd_out),
  .ad_out_en   (ad_out_en),
  .ad_in       (ad_in),
  .ad_in_valid (ad_in_valid),
  .rsp_valid   (rsp_valid),
  .rsp_data    (rsp_data),
  .err_sticky  (err_sticky)
);

// File: tb/sim_sysbus_master.sv
`timescale 1ns/1ps
module sim_sysbus_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_block = 1'b0;
  logic [3:0]  req_nbytes = 4'd1;
  logic [35:0] req_addr = '0;
  logic [63:0] wd_data = '0;
  logic        wd_pop;
  logic        rd_rdy_n = 1'b0;
  logic        wr_rdy_n = 1'b0;
  logic [63:0] ad_out;
  logic [7:0]  adc_out;
  logic [8:0]  cmd_out;
  logic        ad_out_en;
  logic [63:0] ad_in = '0;
  logic [7:0]  adc_in = '0;
  logic [8:0]  cmd_in = '0;
  logic        ad_in_valid = 1'b0;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        rsp_last;
  logic        rsp_err;
  logic        err_sticky;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sysbus_master u0 (.*);

  function automatic logic [7:0] par8(input logic [63:0] d);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ^d[8*i +: 8];
    return p;
  endfunction

  function automatic logic [63:0] pat(input int seed, input int i);
    return {32'hC0DE_0000 + 32'(seed), 32'h1357_9BDF ^ 32'(i * 32'h0101_0101)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Issue a request and check its address cycle.
  task automatic issue(input bit wr, input bit blk, input int nb, input logic [35:0] a);
    logic [8:0] ecmd;
    req_valid  = 1'b1;
    req_write  = wr;
    req_block  = blk;
    req_nbytes = 4'(nb);
    req_addr   = a;
    #1;
    chk(req_ready == 1'b1, "R5 ready with device ready", 64'(req_ready), 64'd1);
    cyc();
    req_valid = 1'b0;
    #1;
    ecmd = {1'b0, 2'b00, wr, blk, 1'b0, blk ? 3'b000 : 3'(nb - 1)};
    chk(ad_out_en == 1'b1, "R2 address cycle driven", 64'(ad_out_en), 64'd1);
    chk(ad_out == 64'(a), "R2 address value", ad_out, 64'(a));
    chk(cmd_out == ecmd, "R2 address command", 64'(cmd_out), 64'(ecmd));
    chk(adc_out == par8(ad_out), "R4 address parity", 64'(adc_out), 64'(par8(ad_out)));
  endtask

  task automatic t_reset();
    chk(ad_out_en == 1'b0 && wd_pop == 1'b0, "R1 bus idle in reset",
        64'({ad_out_en, wd_pop}), 64'd0);
    chk(rsp_valid == 1'b0 && err_sticky == 1'b0, "R1 status clear in reset",
        64'({rsp_valid, err_sticky}), 64'd0);
    rst = 1'b0;
    #1;
    chk(ad_out_en == 1'b0 && rsp_valid == 1'b0 && err_sticky == 1'b0,
        "R1 outputs after reset", 64'({ad_out_en, rsp_valid, err_sticky}), 64'd0);
    chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
  endtask

  task automatic t_write(input bit blk, input int nb, input logic [35:0] a, input int seed);
    int beats = blk ? 4 : 1;
    issue(1'b1, blk, nb, a);
    wd_data = pat(seed, 0);
    for (int i = 0; i < beats; i++) begin
      logic [8:0] ecmd;
      chk(wd_pop == 1'b1, "R3 pop before data cycle", 64'(wd_pop), 64'd1);
      cyc();
      #1;
      ecmd = {1'b1, (i == beats - 1), 1'b0, 6'd0};
      chk(ad_out_en == 1'b1 && ad_out == pat(seed, i), "R3 write data word",
          ad_out, pat(seed, i));
      chk(cmd_out == ecmd, "R3 data command/last", 64'(cmd_out), 64'(ecmd));
      chk(adc_out == par8(ad_out), "R4 data parity", 64'(adc_out), 64'(par8(ad_out)));
      wd_data = pat(seed, i + 1);
    end
    chk(wd_pop == 1'b0, "R3 no pop after last", 64'(wd_pop), 64'd0);
    cyc();
    #1;
    chk(ad_out_en == 1'b0, "R10 bus released after write", 64'(ad_out_en), 64'd0);
  endtask

  // gap: idle cycles before each word; bad_beat: lane corrupted; ef_beat: error flag set
  task automatic t_read(input bit blk, input int nb, input logic [35:0] a, input int seed,
                        input int gap, input int bad_beat, input int ef_beat,
                        input bit exp_sticky);
    int beats = blk ? 4 : 1;
    issue(1'b0, blk, nb, a);
    chk(req_ready == 1'b0, "R8 held off while read pending", 64'(req_ready), 64'd0);
    for (int i = 0; i < beats; i++) begin
      bit last = (i == beats - 1);
      bit eerr = (i == bad_beat) || (i == ef_beat);
      for (int g = 0; g < gap + i; g++) begin
        cyc();
        #1;
        chk(rsp_valid == 1'b0 && ad_out_en == 1'b0, "R6/R10 quiet during gap",
            64'({rsp_valid, ad_out_en}), 64'd0);
      end
      ad_in       = pat(seed, i);
      adc_in      = par8(pat(seed, i)) ^ ((i == bad_beat) ? 8'h04 : 8'h00);
      cmd_in      = {1'b1, last, (i == ef_beat), 6'd0};
      ad_in_valid = 1'b1;
      cyc();
      ad_in_valid = 1'b0;
      #1;
      chk(rsp_valid == 1'b1 && rsp_data == pat(seed, i), "R6 read word delivered",
          rsp_data, pat(seed, i));
      chk(rsp_last == last, "R6 last marker", 64'(rsp_last), 64'(last));
      chk(rsp_err == eerr, "R7 per-word error", 64'(rsp_err), 64'(eerr));
      chk(req_ready == last, "R8 ready only after last word", 64'(req_ready), 64'(last));
    end
    chk(err_sticky == exp_sticky, "R7 sticky status", 64'(err_sticky), 64'(exp_sticky));
  endtask

  task automatic t_ready_gate();
    rd_rdy_n  = 1'b1;
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = 36'h0_0000_1000;
    #1;
    chk(req_ready == 1'b0, "R5 read blocked by rd_rdy_n", 64'(req_ready), 64'd0);
    cyc();
    #1;
    chk(ad_out_en == 1'b0, "R5 no read address cycle", 64'(ad_out_en), 64'd0);
    rd_rdy_n  = 1'b0;
    wr_rdy_n  = 1'b1;
    req_write = 1'b1;
    #1;
    chk(req_ready == 1'b0, "R5 write blocked by wr_rdy_n", 64'(req_ready), 64'd0);
    cyc();
    #1;
    chk(ad_out_en == 1'b0, "R5 no write address cycle", 64'(ad_out_en), 64'd0);
    req_valid = 1'b0;
    wr_rdy_n  = 1'b0;
  endtask

  task automatic t_stray();
    ad_in       = 64'hDEAD_BEEF_0000_0001;
    adc_in      = par8(ad_in);
    cmd_in      = {1'b1, 1'b1, 1'b0, 6'd0};
    ad_in_valid = 1'b1;
    cyc();
    ad_in_valid = 1'b0;
    #1;
    chk(rsp_valid == 1'b0, "R9 data ignored with no read pending", 64'(rsp_valid), 64'd0);
    chk(req_ready == 1'b1, "R9 idle after stray data", 64'(req_ready), 64'd1);
    issue(1'b0, 1'b0, 2, 36'h0_0000_2002);
    cmd_in      = {1'b1, 1'b1, 1'b0, 6'b000101};
    ad_in_valid = 1'b1;
    cyc();
    ad_in_valid = 1'b0;
    #1;
    chk(rsp_valid == 1'b0, "R9 malformed command ignored", 64'(rsp_valid), 64'd0);
    chk(req_ready == 1'b0, "R9 read still pending", 64'(req_ready), 64'd0);
    ad_in       = pat(9, 0);
    adc_in      = par8(ad_in);
    cmd_in      = {1'b1, 1'b1, 1'b0, 6'd0};
    ad_in_valid = 1'b1;
    cyc();
    ad_in_valid = 1'b0;
    #1;
    chk(rsp_valid == 1'b1 && rsp_data == pat(9, 0), "R6 word after malformed cycle",
        rsp_data, pat(9, 0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    @(negedge clk);
    t_write(1'b0, 3, 36'h1_2345_6785, 1);
    t_write(1'b1, 8, 36'h0_8000_0040, 2);
    t_read(1'b0, 8, 36'h0_0000_0100, 3, 0, -1, -1, 1'b0);
    t_read(1'b1, 8, 36'h0_0000_0200, 4, 2, -1, -1, 1'b0);
    t_ready_gate();
    t_stray();
    t_read(1'b0, 4, 36'h0_0000_0304, 5, 1, -1, 0, 1'b0);
    t_read(1'b1, 8, 36'h0_0000_0400, 6, 0, 2, -1, 1'b1);
    t_read(1'b0, 1, 36'h0_0000_0507, 7, 0, -1, -1, 1'b1);
    t_write(1'b0, 8, 36'h0_0000_0600, 8);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule